// File: doc/BRIEF.md
# Wormhole Crossbar Switch

This block is an N-by-N crossbar for byte-wide packet links. Each byte travels with a token flag. A packet is made of a header of one or two bytes, any number of body bytes, and a closing trailer token. When an input has collected its header, it presents the header value as a lookup key. An external route block returns the output index for that key. The input then asks for that output. Once the output is granted, the input keeps it for the whole packet: first the stored header bytes are replayed, then the body bytes flow straight through, and the connection closes when the trailer token passes the output.

A packet whose output is already taken is not dropped and is not buffered whole. It stays stalled at its input with its header held, and it exerts backpressure on its link until the output frees. Each output has its own round-robin arbiter among the inputs waiting for it. Outputs are independent, so packets bound for different outputs move at the same time. Flow control on both sides uses valid/ready. An output's ready reaches the connected input's ready in the same cycle.

Top module: `wormhole_xbar`

## Requirements
- R1: While reset is held and in the first cycle after it, every in_ready is high and every out_valid is low.
- R2: The HDR_LEN header bytes of a packet (header bytes carry tok=0) select the output given by rt_port when the last header byte is accepted. That output then carries the header bytes in arrival order, the body bytes, and the trailer, with nothing lost and nothing duplicated.
- R3: A connection stays open until the trailer (tok=1) is accepted at the output, and it closes then. Trailer data 8'h00 marks end of packet and 8'h01 marks end of message, and both close the connection. The same input may then route its next packet to another output.
- R4: An input whose target output is held by another input accepts no byte after its header (in_ready low). An output never interleaves bytes from two packets.
- R5: Each output grants, among the inputs waiting for it, the first index at or after a pointer, with wrap-around. The pointer is 0 after reset and moves to one past each granted index. A grant is taken only while the output is free.
- R6: While an input is connected, its in_ready equals its output's out_ready in the same cycle. A stalled output keeps presenting the pending byte.
- R7: A token byte offered to an input that is waiting for a header is accepted and discarded, and it appears on no output.
- R8: rt_key is {first header byte, current byte} when HDR_LEN=2, and {8'h00, current byte} when HDR_LEN=1.
- R9: Packets bound for distinct outputs are carried concurrently, each intact, under arbitrary out_ready patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N | Byte offered on each input |
| in_data | input | 8*N | Byte of each input, input i at bits [8i+7:8i] |
| in_tok | input | N | Byte of each input is a token |
| in_ready | output | N | Input byte accepted this cycle when valid |
| rt_key | output | 16*N | Header key of each input for the route lookup |
| rt_port | input | PW*N | Output index returned by the route lookup for each key |
| out_valid | output | N | Byte presented on each output |
| out_data | output | 8*N | Byte of each output |
| out_tok | output | N | Output byte is a token |
| out_ready | input | N | Downstream accepts the output byte |

## Verification
The assertions assume that the route lookup always returns an index below N, that the lookup is purely combinational on rt_key, and that header bytes never carry the token flag. The stimulus meets all three. Its route model takes the two low bits of the key with four ports, and only trailers and deliberately stray tokens carry the flag. The properties cover when an output may be valid, how long a connection is held, that an owner is stalled when its output is not ready, and that no input holds two outputs. Ordering and the absence of interleaving are judged from the byte streams recorded at the outputs.

// File: rtl/wx_pkg.sv
package wx_pkg;

    // Per-input progress through a packet
    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,   // collecting header bytes
        ST_WAIT = 2'd1,   // header held, asking for / replaying into output
        ST_BODY = 2'd2    // connected, bytes flow through
    } in_state_e;

    // One link symbol
    typedef struct packed {
        logic       tok;
        logic [7:0] data;
    } flit_t;

    // Route key built from the held first byte and the byte now offered
    function automatic logic [15:0] route_key(input logic [7:0] held,
                                              input logic [7:0] cur,
                                              input logic       two_byte);
        return two_byte ? {held, cur} : {8'h00, cur};
    endfunction

    // Any token passing a connection ends it
    function automatic logic ends_path(input flit_t f);
        return f.tok;
    endfunction

endpackage

// File: rtl/wx_rr_arb.sv
module wx_rr_arb #(
    parameter  int N  = 32,
    localparam int PW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          en,
    output logic          hit,
    output logic [PW-1:0] pick
);
    logic [PW-1:0] ptr;
    int            idx;

    always_comb begin
        hit  = 1'b0;
        pick = '0;
        idx  = 0;
        for (int k = 0; k < N; k++) begin
            idx = int'(ptr) + k;
            if (idx >= N) idx = idx - N;
            if (!hit && req[idx[PW-1:0]]) begin
                hit  = 1'b1;
                pick = idx[PW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (en && hit) begin
            ptr <= (pick == PW'(N - 1)) ? '0 : pick + 1'b1;
        end
    end

endmodule

// File: rtl/wx_in_port.sv
module wx_in_port
    import wx_pkg::*;
#(
    parameter  int N       = 32,
    parameter  int HDR_LEN = 2,
    localparam int PW      = $clog2(N),
    localparam int HW      = (HDR_LEN > 1) ? $clog2(HDR_LEN) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          up_valid,
    input  logic [7:0]    up_data,
    input  logic          up_tok,
    output logic          up_ready,
    output logic [15:0]   key,
    input  logic [PW-1:0] key_port,
    input  logic          linked,
    input  logic          dn_ready,
    output logic          want,
    output logic [PW-1:0] dest,
    output logic          dn_valid,
    output flit_t         dn_flit
);
    in_state_e     st;
    logic [7:0]    hbuf [HDR_LEN];
    logic [HW-1:0] hidx;
    logic          last_hdr;

    assign last_hdr = (hidx == HW'(HDR_LEN - 1));

    generate
        if (HDR_LEN > 1) begin : g_two
            assign key = route_key(hbuf[0], up_data, 1'b1);
        end else begin : g_one
            assign key = route_key(8'h00, up_data, 1'b0);
        end
    endgenerate

    always_comb begin
        up_ready = 1'b0;
        want     = 1'b0;
        dn_valid = 1'b0;
        dn_flit  = '{tok: 1'b0, data: hbuf[hidx]};
        case (st)
            ST_HDR:  up_ready = 1'b1;
            ST_WAIT: begin
                want     = !linked;
                dn_valid = linked;
            end
            ST_BODY: begin
                up_ready = dn_ready;
                dn_valid = up_valid;
                dn_flit  = '{tok: up_tok, data: up_data};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_HDR;
            hidx <= '0;
            dest <= '0;
            for (int b = 0; b < HDR_LEN; b++) hbuf[b] <= 8'h00;
        end else begin
            case (st)
                ST_HDR: begin
                    if (up_valid && !up_tok) begin
                        hbuf[hidx] <= up_data;
                        if (last_hdr) begin
                            dest <= key_port;
                            hidx <= '0;
                            st   <= ST_WAIT;
                        end else begin
                            hidx <= hidx + 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (linked && dn_ready) begin
                        if (last_hdr) begin
                            hidx <= '0;
                            st   <= ST_BODY;
                        end else begin
                            hidx <= hidx + 1'b1;
                        end
                    end
                end
                ST_BODY: begin
                    if (up_valid && dn_ready && ends_path(dn_flit)) st <= ST_HDR;
                end
                default: st <= ST_HDR;
            endcase
        end
    end

endmodule

// File: rtl/wx_out_port.sv
module wx_out_port
    import wx_pkg::*;
#(
    parameter  int N  = 32,
    localparam int PW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  src_valid,
    input  flit_t         src [N],
    input  logic          out_ready,
    output logic          out_valid,
    output flit_t         out_flit,
    output logic          busy,
    output logic [PW-1:0] owner
);
    logic          hit;
    logic [PW-1:0] pick;

    wx_rr_arb #(.N(N)) u_arb (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .en   (!busy),
        .hit  (hit),
        .pick (pick)
    );

    always_comb begin
        out_valid = busy && src_valid[owner];
        out_flit  = src[owner];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            owner <= '0;
        end else if (!busy) begin
            if (hit) begin
                busy  <= 1'b1;
                owner <= pick;
            end
        end else if (out_valid && out_ready && ends_path(out_flit)) begin
            busy <= 1'b0;
        end
    end

endmodule

// File: rtl/wormhole_xbar.sv
module wormhole_xbar
    import wx_pkg::*;
#(
    parameter  int N       = 32,
    parameter  int HDR_LEN = 2,
    localparam int PW      = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    in_valid,
    input  logic [8*N-1:0]  in_data,
    input  logic [N-1:0]    in_tok,
    output logic [N-1:0]    in_ready,
    output logic [16*N-1:0] rt_key,
    input  logic [PW*N-1:0] rt_port,
    output logic [N-1:0]    out_valid,
    output logic [8*N-1:0]  out_data,
    output logic [N-1:0]    out_tok,
    input  logic [N-1:0]    out_ready
);
    flit_t          src      [N];
    flit_t          oflit    [N];
    logic [PW-1:0]  dest     [N];
    logic [PW-1:0]  owner    [N];
    logic [N-1:0]   src_valid;
    logic [N-1:0]   want;
    logic [N-1:0]   linked;
    logic [N-1:0]   dn_ready;
    logic [N-1:0]   out_busy;
    logic [PW*N-1:0] owner_flat;

    generate
        for (genvar i = 0; i < N; i++) begin : g_in
            assign linked[i]   = out_busy[dest[i]] && (owner[dest[i]] == PW'(i));
            assign dn_ready[i] = out_ready[dest[i]];

            wx_in_port #(.N(N), .HDR_LEN(HDR_LEN)) u_in (
                .clk      (clk),
                .rst      (rst),
                .up_valid (in_valid[i]),
                .up_data  (in_data[8*i +: 8]),
                .up_tok   (in_tok[i]),
                .up_ready (in_ready[i]),
                .key      (rt_key[16*i +: 16]),
                .key_port (rt_port[PW*i +: PW]),
                .linked   (linked[i]),
                .dn_ready (dn_ready[i]),
                .want     (want[i]),
                .dest     (dest[i]),
                .dn_valid (src_valid[i]),
                .dn_flit  (src[i])
            );
        end

        for (genvar o = 0; o < N; o++) begin : g_out
            logic [N-1:0] req_col;

            always_comb begin
                for (int i = 0; i < N; i++) begin
                    req_col[i] = want[i] && (dest[i] == PW'(o));
                end
            end

            wx_out_port #(.N(N)) u_out (
                .clk       (clk),
                .rst       (rst),
                .req       (req_col),
                .src_valid (src_valid),
                .src       (src),
                .out_ready (out_ready[o]),
                .out_valid (out_valid[o]),
                .out_flit  (oflit[o]),
                .busy      (out_busy[o]),
                .owner     (owner[o])
            );

            assign out_data[8*o +: 8]     = oflit[o].data;
            assign out_tok[o]             = oflit[o].tok;
            assign owner_flat[PW*o +: PW] = owner[o];
        end
    endgenerate

endmodule

// File: rtl/wormhole_xbar_chk.sv
module wormhole_xbar_chk #(
    parameter  int N  = 32,
    localparam int PW = $clog2(N)
) (
    input logic            clk,
    input logic            rst,
    input logic [N-1:0]    out_valid,
    input logic [N-1:0]    out_ready,
    input logic [N-1:0]    out_tok,
    input logic [N-1:0]    in_ready,
    input logic [N-1:0]    busy,
    input logic [PW*N-1:0] owner_flat
);
    logic [N-1:0] held_by [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int o = 0; o < N; o++) begin
                held_by[i][o] = busy[o] && (owner_flat[PW*o +: PW] == PW'(i));
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (out_valid == '0) && (busy == '0));

    generate
        for (genvar o = 0; o < N; o++) begin : g_o
            // R4
            valid_needs_path_chk: assert property (@(posedge clk) disable iff (rst)
                out_valid[o] |-> busy[o]);

            // R3
            path_held_chk: assert property (@(posedge clk) disable iff (rst)
                (busy[o] && !(out_valid[o] && out_ready[o] && out_tok[o]))
                |=> busy[o] && $stable(owner_flat[PW*o +: PW]));

            // R3
            path_closed_chk: assert property (@(posedge clk) disable iff (rst)
                (out_valid[o] && out_ready[o] && out_tok[o]) |=> !busy[o]);

            // R6
            owner_stalled_chk: assert property (@(posedge clk) disable iff (rst)
                (busy[o] && !out_ready[o]) |-> !in_ready[owner_flat[PW*o +: PW]]);
        end

        for (genvar i = 0; i < N; i++) begin : g_i
            // R4
            single_path_chk: assert property (@(posedge clk) disable iff (rst)
                $countones(held_by[i]) <= 1);
        end
    endgenerate

endmodule

bind wormhole_xbar wormhole_xbar_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_tok    (out_tok),
    .in_ready   (in_ready),
    .busy       (out_busy),
    .owner_flat (owner_flat)
);

// File: tb/wormhole_xbar_test.sv
`timescale 1ns/1ps
module wormhole_xbar_test;
    localparam int NP = 4;
    localparam int PB = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [NP-1:0]    in_valid, in_tok, in_ready, out_valid, out_tok, out_ready;
    logic [8*NP-1:0]  in_data, out_data;
    logic [16*NP-1:0] rt_key;
    logic [PB*NP-1:0] rt_port;

    logic       v_in [NP];
    logic [7:0] d_in [NP];
    logic       t_in [NP];
    logic       r_out [NP];

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            in_valid[p]         = v_in[p];
            in_data[8*p +: 8]   = d_in[p];
            in_tok[p]           = t_in[p];
            out_ready[p]        = r_out[p];
            rt_port[PB*p +: PB] = rt_key[16*p +: PB];
        end
    end

    wormhole_xbar #(.N(NP), .HDR_LEN(2)) uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_tok(in_tok), .in_ready(in_ready),
        .rt_key(rt_key), .rt_port(rt_port),
        .out_valid(out_valid), .out_data(out_data), .out_tok(out_tok), .out_ready(out_ready)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [8:0] got_q [NP][64];
    logic [8:0] exp_q [NP][64];
    int got_n [NP];
    int exp_n [NP];

    bit       bp_on = 0;
    logic [7:0] lfsr = 8'hA5;

    always @(negedge clk) begin
        if (bp_on) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            for (int o = 0; o < NP; o++) r_out[o] = lfsr[o] | lfsr[o+4];
        end
    end

    always @(negedge clk) begin
        #1;
        for (int o = 0; o < NP; o++) begin
            if (out_valid[o] && out_ready[o] && got_n[o] < 64) begin
                got_q[o][got_n[o]] = {out_tok[o], out_data[8*o +: 8]};
                got_n[o]++;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input int p, input bit tok, input logic [7:0] d);
        @(negedge clk);
        v_in[p] = 1'b1;
        t_in[p] = tok;
        d_in[p] = d;
        #1;
        while (!in_ready[p]) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic send_pkt(input int p, input logic [7:0] hi, input logic [7:0] lo,
                            input logic [7:0] seed, input int len, input bit eom);
        send_byte(p, 1'b0, hi);
        send_byte(p, 1'b0, lo);
        for (int k = 0; k < len; k++) send_byte(p, 1'b0, 8'(seed + k));
        send_byte(p, 1'b1, eom ? 8'h01 : 8'h00);
        @(negedge clk);
        v_in[p] = 1'b0;
        t_in[p] = 1'b0;
    endtask

    task automatic push_exp(input int o, input logic [8:0] s);
        if (exp_n[o] < 64) begin
            exp_q[o][exp_n[o]] = s;
            exp_n[o]++;
        end
    endtask

    task automatic expect_pkt(input int o, input logic [7:0] hi, input logic [7:0] lo,
                              input logic [7:0] seed, input int len, input bit eom);
        push_exp(o, {1'b0, hi});
        push_exp(o, {1'b0, lo});
        for (int k = 0; k < len; k++) push_exp(o, {1'b0, 8'(seed + k)});
        push_exp(o, {1'b1, eom ? 8'h01 : 8'h00});
    endtask

    task automatic clear_logs();
        for (int o = 0; o < NP; o++) begin
            got_n[o] = 0;
            exp_n[o] = 0;
        end
    endtask

    task automatic compare_logs(input string rq);
        for (int o = 0; o < NP; o++) begin
            bit ok;
            int act;
            int exp;
            ok  = (got_n[o] == exp_n[o]);
            act = got_n[o];
            exp = exp_n[o];
            if (ok) begin
                for (int k = 0; k < exp_n[o]; k++) begin
                    if (ok && got_q[o][k] !== exp_q[o][k]) begin
                        ok  = 0;
                        act = int'(got_q[o][k]);
                        exp = int'(exp_q[o][k]);
                    end
                end
            end
            chk(ok, rq, $sformatf("output %0d stream", o), act, exp);
        end
    endtask

    // R1
    task automatic t_reset();
        idle(3);
        #1;
        chk(in_ready == 4'hF, "R1", "in_ready in reset", int'(in_ready), 'hF);
        chk(out_valid == 4'h0, "R1", "out_valid in reset", int'(out_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(in_ready == 4'hF, "R1", "in_ready after reset", int'(in_ready), 'hF);
        chk(out_valid == 4'h0, "R1", "out_valid after reset", int'(out_valid), 0);
    endtask

    // R2 R3: one packet through one output
    task automatic t_single();
        clear_logs();
        send_pkt(0, 8'h00, 8'h02, 8'h40, 3, 1'b0);
        expect_pkt(2, 8'h00, 8'h02, 8'h40, 3, 1'b0);
        idle(5);
        compare_logs("R2 R3");
    endtask

    // R8 R3: key byte order, end of message closes, next packet elsewhere
    task automatic t_order_reroute();
        clear_logs();
        send_pkt(1, 8'h03, 8'h01, 8'h50, 2, 1'b1);
        send_pkt(1, 8'h01, 8'h00, 8'h60, 1, 1'b0);
        expect_pkt(1, 8'h03, 8'h01, 8'h50, 2, 1'b1);
        expect_pkt(0, 8'h01, 8'h00, 8'h60, 1, 1'b0);
        idle(5);
        compare_logs("R8 R3");
    endtask

    // R7: stray token while waiting for a header
    task automatic t_stray();
        clear_logs();
        send_byte(2, 1'b1, 8'h00);
        @(negedge clk);
        v_in[2] = 1'b0;
        t_in[2] = 1'b0;
        idle(4);
        compare_logs("R7");
        send_pkt(2, 8'h00, 8'h03, 8'h70, 2, 1'b0);
        expect_pkt(3, 8'h00, 8'h03, 8'h70, 2, 1'b0);
        idle(5);
        compare_logs("R7");
    endtask

    // R4 R5 R6: contention for output 2 with the pointer past 0
    task automatic t_contend();
        clear_logs();
        @(negedge clk);
        r_out[2] = 1'b0;
        fork
            send_pkt(1, 8'h00, 8'h02, 8'h80, 2, 1'b0);
        join_none
        idle(8);
        #1;
        chk(out_valid[2] && out_data[23:16] == 8'h00 && !out_tok[2], "R6",
            "stalled output shows header", int'({out_valid[2], out_data[23:16]}), 'h100);
        chk(!in_ready[1], "R6", "owner in_ready while stalled", int'(in_ready[1]), 0);
        fork
            send_pkt(0, 8'h00, 8'h02, 8'h90, 3, 1'b1);
            send_pkt(3, 8'h00, 8'h02, 8'hA0, 1, 1'b0);
        join_none
        idle(8);
        #1;
        chk(!in_ready[0] && !in_ready[3], "R4", "waiting inputs stalled",
            int'({in_ready[3], in_ready[0]}), 0);
        chk(out_valid == 4'b0100, "R4", "only held output valid", int'(out_valid), 'h4);
        @(negedge clk);
        r_out[2] = 1'b1;
        wait fork;
        idle(6);
        expect_pkt(2, 8'h00, 8'h02, 8'h80, 2, 1'b0);
        expect_pkt(2, 8'h00, 8'h02, 8'hA0, 1, 1'b0);
        expect_pkt(2, 8'h00, 8'h02, 8'h90, 3, 1'b1);
        compare_logs("R5 R4");
    endtask

    // R6 R9: four concurrent packets to distinct outputs under random backpressure
    task automatic t_parallel();
        clear_logs();
        @(negedge clk);
        bp_on = 1'b1;
        fork
            send_pkt(0, 8'h00, 8'h03, 8'h10, 5, 1'b0);
            send_pkt(1, 8'h00, 8'h02, 8'h20, 5, 1'b1);
            send_pkt(2, 8'h00, 8'h01, 8'h30, 5, 1'b0);
            send_pkt(3, 8'h00, 8'h00, 8'h40, 5, 1'b1);
        join
        @(negedge clk);
        bp_on = 1'b0;
        for (int o = 0; o < NP; o++) r_out[o] = 1'b1;
        idle(6);
        expect_pkt(3, 8'h00, 8'h03, 8'h10, 5, 1'b0);
        expect_pkt(2, 8'h00, 8'h02, 8'h20, 5, 1'b1);
        expect_pkt(1, 8'h00, 8'h01, 8'h30, 5, 1'b0);
        expect_pkt(0, 8'h00, 8'h00, 8'h40, 5, 1'b1);
        compare_logs("R6 R9");
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin
            v_in[p]  = 1'b0;
            d_in[p]  = 8'h00;
            t_in[p]  = 1'b0;
            r_out[p] = 1'b1;
            got_n[p] = 0;
            exp_n[p] = 0;
        end
        t_reset();
        t_single();
        t_order_reroute();
        t_stray();
        t_contend();
        t_parallel();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule